// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Data Cache

This block is an 8 KB data cache with two ways, placed between a processor load/store port and a lower-level memory. Each request address is cut into a tag, a set index and a block offset. The index picks one set. The tag is compared against the tags of both ways in that set at the same time. When a load hits, the word comes back in the same cycle, taken from whichever way matched.

When a load misses, the processor is stalled and the block address is sent to the lower level. The eight returned words are written into a victim way, and the held load then completes as a hit. Stores are write-through with no write allocate. Every store is offered to a downstream write-buffer port under a valid/ready handshake. A store that hits also updates the cached word. A store that misses leaves the cache untouched.

The victim is chosen by a one-bit-per-set least-recently-used policy by default. A parameter can select a free-running pseudo-random choice instead.

Top module: `wtc_cache2w`

## Requirements
- R1: The address is decoded as word select = addr[4:2], set index = addr[11:5] and tag = addr[33:12]. Bits [1:0] play no part in lookup, since all accesses are whole 32-bit words.
- R2: Reset clears every valid bit, so the first load to any address after reset misses. While idle after reset, cpu_stall, cpu_rvalid, fill_req_valid and wb_valid are all low.
- R3: A load hits when its tag matches a valid way of the indexed set. In that same cycle cpu_rvalid is high, cpu_stall is low and cpu_rdata holds the addressed word of the matching way.
- R4: A load miss raises cpu_stall. From the next cycle fill_req_valid is asserted with fill_req_addr = addr[33:5], and it is held steady until fill_req_ready is seen.
- R5: After the request is accepted, the cache takes exactly eight words, one on each cycle that fill_rsp_valid is high, in order from word 0 to word 7. It stores them in the victim way and marks that way valid. The stalled load then hits and returns its word.
- R6: For the victim, an invalid way 0 is taken first, then an invalid way 1. When both ways are valid, the way that was not the most recent one hit or filled in that set is evicted.
- R7: Every store drives wb_valid with wb_addr = cpu_addr and wb_data = cpu_wdata. cpu_stall stays high for every cycle that wb_ready is low, and the store completes in the first cycle that wb_ready is high. Loads never drive wb_valid.
- R8: A store hit writes the new data into the cached word in the cycle the write buffer accepts it. A later load returns that data without a miss.
- R9: A store miss does not allocate. Later loads to lines that were already resident still hit, and a load to the stored address misses and returns the written-through data.
- R10: While a refill is in progress, wb_valid and cpu_rvalid stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request present, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 34 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| cpu_rvalid | output | 1 | Load data valid this cycle |
| cpu_rdata | output | 32 | Load data |
| fill_req_valid | output | 1 | Block fetch request |
| fill_req_ready | input | 1 | Lower level accepts the fetch request |
| fill_req_addr | output | 29 | Block address (addr[33:5]) |
| fill_rsp_valid | input | 1 | One refill word is present |
| fill_rsp_data | input | 32 | Refill word |
| wb_valid | output | 1 | Store offered to the write buffer |
| wb_ready | input | 1 | Write buffer accepts the store |
| wb_addr | output | 34 | Store address |
| wb_data | output | 32 | Store data |

## Verification
The hardest situation to reach from the ports is a set where both ways are valid and the recency bit points at a particular way. Only that case separates true LRU eviction from a fixed or random choice. A store miss into such a full set must also leave both lines resident. The stimulus table aims every early access at one set: it fills both ways, touches one of them, forces a third tag in, and then probes which lines still hit. After that, the table sends a store miss into the same full set and probes both residents again.

Directed tests follow the table. They hold back the write-buffer ready signal, delay the fetch acceptance, and insert idle gaps between refill words.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      MC_IDLE,
      MC_REQ,
      MC_FILL
   } mc_state_e;

   localparam int unsigned REPL_LRU  = 0;
   localparam int unsigned REPL_RAND = 1;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
   import wtc_pkg::*;
#(
   parameter int unsigned IDX_W = 7,
   parameter int unsigned TAG_W = 22,
   parameter int unsigned REPL  = REPL_LRU,
   localparam int unsigned SETS = 1 << IDX_W,
   localparam int unsigned WAYS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic             lk_way,
   output logic             lk_victim,
   input  logic             touch_en,
   input  logic             touch_way,
   input  logic             inst_en,
   input  logic             inst_way,
   input  logic [IDX_W-1:0] inst_idx,
   input  logic [TAG_W-1:0] inst_tag
);
   logic [WAYS-1:0] way_vld;
   logic [WAYS-1:0] way_match;
   logic            repl_pick;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q <= '0;
         else if (inst_en && inst_way == 1'(g))
            vld_q[inst_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (inst_en && inst_way == 1'(g))
            tag_q[inst_idx] <= inst_tag;
      end

      assign way_vld[g]   = vld_q[lk_idx];
      assign way_match[g] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   end

   assign lk_hit = |way_match;
   assign lk_way = way_match[1];

   if (REPL == REPL_LRU) begin : g_lru
      // per set: the way to evict next
      logic [SETS-1:0] lru_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lru_q <= '0;
         else if (inst_en)
            lru_q[inst_idx] <= ~inst_way;
         else if (touch_en)
            lru_q[lk_idx] <= ~touch_way;
      end
      assign repl_pick = lru_q[lk_idx];
   end else begin : g_rand
      logic [7:0] lfsr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lfsr_q <= 8'h01;
         else
            lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
      end
      assign repl_pick = lfsr_q[0];
   end

   always_comb begin
      if (!way_vld[0])
         lk_victim = 1'b0;
      else if (!way_vld[1])
         lk_victim = 1'b1;
      else
         lk_victim = repl_pick;
   end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned WSEL_W = 3,
   localparam int unsigned LINES = 1 << (IDX_W + WSEL_W),
   localparam int unsigned WAYS  = 2
) (
   input  logic              clk,
   input  logic              rd_way,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [WORD_W-1:0] wr_data
);
   logic [WORD_W-1:0] way_data [WAYS];

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [WORD_W-1:0] mem_q [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && wr_way == 1'(g))
            mem_q[{wr_idx, wr_wsel}] <= wr_data;
      end
      assign way_data[g] = mem_q[{rd_idx, rd_wsel}];
   end

   assign rd_data = way_data[rd_way];
endmodule

// File: rtl/wtc_miss_ctrl.sv
module wtc_miss_ctrl
   import wtc_pkg::*;
#(
   parameter int unsigned BLK_W  = 29,
   parameter int unsigned WSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_start,
   input  logic [BLK_W-1:0]  miss_blk,
   input  logic              miss_victim,
   output logic              busy,
   output logic              fill_req_valid,
   input  logic              fill_req_ready,
   output logic [BLK_W-1:0]  fill_blk,
   input  logic              fill_rsp_valid,
   output logic              fill_we,
   output logic [WSEL_W-1:0] fill_wsel,
   output logic              fill_way,
   output logic              fill_last
);
   mc_state_e         state_q;
   logic [BLK_W-1:0]  blk_q;
   logic              way_q;
   logic [WSEL_W-1:0] cnt_q;

   assign busy           = (state_q != MC_IDLE);
   assign fill_req_valid = (state_q == MC_REQ);
   assign fill_blk       = blk_q;
   assign fill_way       = way_q;
   assign fill_wsel      = cnt_q;
   assign fill_we        = (state_q == MC_FILL) && fill_rsp_valid;
   assign fill_last      = fill_we && (cnt_q == {WSEL_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MC_IDLE;
         blk_q   <= '0;
         way_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            MC_IDLE: if (miss_start) begin
               state_q <= MC_REQ;
               blk_q   <= miss_blk;
               way_q   <= miss_victim;
            end
            MC_REQ: if (fill_req_ready) begin
               state_q <= MC_FILL;
               cnt_q   <= '0;
            end
            MC_FILL: if (fill_we) begin
               cnt_q <= cnt_q + 1'b1;
               if (fill_last)
                  state_q <= MC_IDLE;
            end
            default: state_q <= MC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wtc_cache2w.sv
module wtc_cache2w
   import wtc_pkg::*;
#(
   parameter int unsigned ADDR_W = 34,
   parameter int unsigned OFFS_W = 5,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned REPL   = REPL_LRU,
   localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
   localparam int unsigned WSEL_W = OFFS_W - BYTE_W,
   localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFFS_W,
   localparam int unsigned BLK_W  = ADDR_W - OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_stall,
   output logic              cpu_rvalid,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              fill_req_valid,
   input  logic              fill_req_ready,
   output logic [BLK_W-1:0]  fill_req_addr,
   input  logic              fill_rsp_valid,
   input  logic [WORD_W-1:0] fill_rsp_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [WORD_W-1:0] wb_data
);
   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 8");
   end
   if (OFFS_W <= BYTE_W) begin : g_bad_offs
      $error("OFFS_W must exceed the byte-select width");
   end
   if (ADDR_W <= OFFS_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end
   if (REPL != REPL_LRU && REPL != REPL_RAND) begin : g_bad_repl
      $error("REPL selects an unknown replacement policy");
   end

   logic [WSEL_W-1:0] a_wsel;
   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic              hit, hit_way, victim;
   logic              busy;
   logic              fill_we, fill_way, fill_last;
   logic [WSEL_W-1:0] fill_wsel;
   logic              st_acc, st_we, ld_idle;

   assign a_wsel = cpu_addr[OFFS_W-1:BYTE_W];
   assign a_idx  = cpu_addr[OFFS_W+IDX_W-1:OFFS_W];
   assign a_tag  = cpu_addr[ADDR_W-1:OFFS_W+IDX_W];

   assign ld_idle = cpu_req && !cpu_we && !busy;
   assign st_acc  = cpu_req && cpu_we && !busy && wb_ready;
   assign st_we   = st_acc && hit;

   wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .REPL(REPL)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (a_idx),
      .lk_tag    (a_tag),
      .lk_hit    (hit),
      .lk_way    (hit_way),
      .lk_victim (victim),
      .touch_en  ((ld_idle || st_acc) && hit),
      .touch_way (hit_way),
      .inst_en   (fill_last),
      .inst_way  (fill_way),
      .inst_idx  (fill_req_addr[IDX_W-1:0]),
      .inst_tag  (fill_req_addr[BLK_W-1:IDX_W])
   );

   wtc_data_store #(.WORD_W(WORD_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
      .clk     (clk),
      .rd_way  (hit_way),
      .rd_idx  (a_idx),
      .rd_wsel (a_wsel),
      .rd_data (cpu_rdata),
      .wr_en   (fill_we || st_we),
      .wr_way  (fill_we ? fill_way : hit_way),
      .wr_idx  (fill_we ? fill_req_addr[IDX_W-1:0] : a_idx),
      .wr_wsel (fill_we ? fill_wsel : a_wsel),
      .wr_data (fill_we ? fill_rsp_data : cpu_wdata)
   );

   wtc_miss_ctrl #(.BLK_W(BLK_W), .WSEL_W(WSEL_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .miss_start     (ld_idle && !hit),
      .miss_blk       (cpu_addr[ADDR_W-1:OFFS_W]),
      .miss_victim    (victim),
      .busy           (busy),
      .fill_req_valid (fill_req_valid),
      .fill_req_ready (fill_req_ready),
      .fill_blk       (fill_req_addr),
      .fill_rsp_valid (fill_rsp_valid),
      .fill_we        (fill_we),
      .fill_wsel      (fill_wsel),
      .fill_way       (fill_way),
      .fill_last      (fill_last)
   );

   assign cpu_rvalid = ld_idle && hit;
   assign cpu_stall  = cpu_req && (busy || (!cpu_we && !hit) || (cpu_we && !wb_ready));
   assign wb_valid   = cpu_req && cpu_we && !busy;
   assign wb_addr    = cpu_addr;
   assign wb_data    = cpu_wdata;
endmodule

// File: rtl/wtc_cache2w_chk.sv
module wtc_cache2w_chk #(
   parameter int unsigned BLK_W = 29
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_we,
   input logic             cpu_stall,
   input logic             cpu_rvalid,
   input logic             fill_req_valid,
   input logic             fill_req_ready,
   input logic [BLK_W-1:0] fill_req_addr,
   input logic             wb_valid,
   input logic             wb_ready
);
   AST_FILL_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_req_addr)); // R4
   AST_FILL_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_req_valid) |-> $past(cpu_req && !cpu_we && cpu_stall)); // R4
   AST_RSP_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> !cpu_stall && !cpu_we); // R3
   AST_WB_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |-> cpu_stall); // R7
   AST_LOAD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we |-> !wb_valid); // R7
   AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> !wb_valid && !cpu_rvalid); // R10
endmodule

bind wtc_cache2w wtc_cache2w_chk #(.BLK_W(BLK_W)) u_chk (.*);

// File: tb/wtc_cache2w_tb.sv
module wtc_cache2w_tb;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [33:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_stall, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        fill_req_valid;
   logic        fill_req_ready = 1'b0;
   logic [28:0] fill_req_addr;
   logic        fill_rsp_valid = 1'b0;
   logic [31:0] fill_rsp_data = '0;
   logic        wb_valid;
   logic        wb_ready = 1'b1;
   logic [33:0] wb_addr;
   logic [31:0] wb_data;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wtc_cache2w u_dut (.*);

   // memory model: initial contents computed, stores recorded as accepted
   logic [31:0] mem_ov [logic [31:0]];
   function automatic logic [31:0] model_read(input logic [31:0] wa);
      if (mem_ov.exists(wa)) return mem_ov[wa];
      return wa * 32'h9E3779B1 + 32'h01234567;
   endfunction

   int          wb_hold = 0, fm_delay = 0, fm_wait = 0, fm_k = 0;
   bit          fm_gap = 0, fm_skip = 0, fm_busy = 0;
   logic [28:0] fm_blk = '0;

   always @(negedge clk) begin
      wb_ready = (wb_hold == 0);
      if (wb_hold > 0) wb_hold--;
      fill_req_ready = 1'b0;
      fill_rsp_valid = 1'b0;
      if (!rst_n) begin
         fm_busy = 0;
         fm_wait = 0;
      end else if (fm_busy) begin
         if (fm_gap && fm_skip) fm_skip = 0;
         else begin
            fill_rsp_valid = 1'b1;
            fill_rsp_data  = model_read({fm_blk, 3'(fm_k)});
            fm_k++;
            fm_skip = 1;
            if (fm_k == 8) fm_busy = 0;
         end
      end else if (fill_req_valid) begin
         if (fm_wait < fm_delay) fm_wait++;
         else begin
            fill_req_ready = 1'b1;
            fm_blk  = fill_req_addr;
            fm_busy = 1;
            fm_k    = 0;
            fm_wait = 0;
            fm_skip = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   int last_stalls;
   task automatic access(input logic we, input logic [33:0] a, input logic [31:0] d,
                         input logic exp_miss);
      bit missed, quiet_bad, addr_seen;
      logic [28:0] seen_addr;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      missed = cpu_stall; quiet_bad = 0; addr_seen = 0; seen_addr = '0;
      last_stalls = 0;
      while (cpu_stall) begin
         if (!we && (wb_valid || cpu_rvalid)) quiet_bad = 1;
         if (fill_req_valid && !addr_seen) begin addr_seen = 1; seen_addr = fill_req_addr; end
         last_stalls++;
         @(negedge clk); #1;
      end
      chk(missed == exp_miss, "R3 R4 R6 R9 miss/hit", 64'(missed), 64'(exp_miss));
      if (we) begin
         chk(wb_valid && wb_addr == a && wb_data == d, "R7 store forward",
             {wb_data, 31'(wb_addr), wb_valid}, {d, 31'(a), 1'b1});
         mem_ov[a[33:2]] = d;
      end else begin
         chk(cpu_rvalid && cpu_rdata == model_read(a[33:2]), "R3 R5 load data",
             {31'(cpu_rvalid), cpu_rdata}, {31'd1, model_read(a[33:2])});
         if (missed) begin
            chk(!quiet_bad, "R10 quiet during refill", 64'(quiet_bad), 64'd0);
            chk(addr_seen && seen_addr == a[33:5], "R4 fetch address",
                64'(seen_addr), 64'(a[33:5]));
         end
      end
      @(posedge clk);
   endtask

   task automatic go_idle();
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [33:0] addr;
      logic [31:0] wdata;
      logic        miss;
   } vec_t;

   localparam logic [21:0] T1 = 22'h0001A, T2 = 22'h0002B, T3 = 22'h0003C, T9 = 22'h00099;
   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b0, {T1, 7'd3, 3'd2, 2'b00}, 32'h0, 1'b1},          // R2 R5 way0 filled
      '{1'b0, {T1, 7'd3, 3'd7, 2'b00}, 32'h0, 1'b0},          // R3 R5 last word
      '{1'b0, {T1, 7'd3, 3'd0, 2'b00}, 32'h0, 1'b0},          // R5 first word
      '{1'b0, {T2, 7'd3, 3'd1, 2'b00}, 32'h0, 1'b1},          // R6 invalid way1
      '{1'b0, {T1, 7'd3, 3'd5, 2'b00}, 32'h0, 1'b0},          // R6 touch way0
      '{1'b0, {T3, 7'd3, 3'd4, 2'b00}, 32'h0, 1'b1},          // R6 evict T2
      '{1'b0, {T1, 7'd3, 3'd3, 2'b00}, 32'h0, 1'b0},          // R6 T1 kept
      '{1'b0, {T2, 7'd3, 3'd1, 2'b00}, 32'h0, 1'b1},          // R6 T2 gone
      '{1'b1, {T1, 7'd3, 3'd3, 2'b00}, 32'h0000AAAA, 1'b0},   // R8 store hit
      '{1'b0, {T1, 7'd3, 3'd3, 2'b00}, 32'h0, 1'b0},          // R8 new data
      '{1'b1, {T9, 7'd3, 3'd0, 2'b00}, 32'h0000BBBB, 1'b0},   // R9 store miss
      '{1'b0, {T1, 7'd3, 3'd0, 2'b00}, 32'h0, 1'b0},          // R9 T1 resident
      '{1'b0, {T2, 7'd3, 3'd1, 2'b00}, 32'h0, 1'b0},          // R9 T2 resident
      '{1'b0, {T9, 7'd3, 3'd0, 2'b00}, 32'h0, 1'b1},          // R9 not allocated
      '{1'b0, {T1, 7'd3, 3'd3, 2'b00}, 32'h0, 1'b1},          // R7 written through
      '{1'b0, {22'h3FFFFF, 7'd127, 3'd7, 2'b00}, 32'h0, 1'b1}, // R1 top corner
      '{1'b0, {22'h3FFFFF, 7'd127, 3'd7, 2'b11}, 32'h0, 1'b0}, // R1 byte bits ignored
      '{1'b0, {22'h3FFFFF, 7'd0, 3'd7, 2'b00}, 32'h0, 1'b1},   // R1 index differs
      '{1'b0, {22'h000000, 7'd127, 3'd7, 2'b00}, 32'h0, 1'b1}  // R1 tag differs
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R2 idle outputs after reset
      chk(!cpu_stall && !cpu_rvalid && !fill_req_valid && !wb_valid, "R2 idle after reset",
          {cpu_stall, cpu_rvalid, fill_req_valid, wb_valid}, 4'b0);

      for (int i = 0; i < NV; i++)
         access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].miss);

      // R7 write-buffer backpressure on a store hit (T1 now in set 3)
      wb_hold = 3;
      access(1'b1, {T1, 7'd3, 3'd6, 2'b00}, 32'h00C0FFEE, 1'b1);
      chk(last_stalls == 3, "R7 stall while not ready", 64'(last_stalls), 64'd3);
      access(1'b0, {T1, 7'd3, 3'd6, 2'b00}, 32'h0, 1'b0); // R8

      // R4 R5 delayed acceptance and gaps between refill words
      fm_delay = 2; fm_gap = 1;
      access(1'b0, {22'h0002A, 7'd64, 3'd5, 2'b00}, 32'h0, 1'b1);
      access(1'b0, {22'h0002A, 7'd64, 3'd0, 2'b00}, 32'h0, 1'b0);
      fm_delay = 0; fm_gap = 0;

      // R2 reset drops every resident line
      go_idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b0, {22'h0002A, 7'd64, 3'd0, 2'b00}, 32'h0, 1'b1);
      go_idle();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule